// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Bank

This block is the software-visible register bank of an Ethernet DMA engine. A host writes and reads 32-bit words over a simple single-cycle bus. The bank holds the bus-mode word, the receive and transmit descriptor-list base addresses, the current descriptor pointers, the DMA control word and the interrupt-enable mask. It returns a fixed version word. It keeps the DMA status word, which the transmit and receive engines raise through per-bit set pulses and which software acknowledges by writing ones.

A single level interrupt line is raised while any status bit is both set and enabled. A write to the transmit poll-demand word stores nothing. Instead, it produces a one-cycle kick toward the transmit engine. Writing a base address also loads the matching current-pointer register, so that a new list starts at its head.

The reset input is asynchronous and active low. Its release is synchronized inside the block, so the registers leave reset two clock edges after the input rises.

Top module: `dma_csr_bank`

## Requirements
- R1: The byte address is shifted right by 2 to form a word index. The registers decode at these word indices: bus mode 0x3C0, transmit poll demand 0x3C1, receive list base 0x3C3, transmit list base 0x3C4, status 0x3C5, control 0x3C6, interrupt enable 0x3C7, current transmit descriptor 0x3D2, current receive descriptor 0x3D3, version 0x008. A written word reads back unchanged, apart from the exceptions below.
- R2: A write to the status word clears every status bit written as 1 and leaves the other status bits unchanged.
- R3: The status word takes the OR of the transmit-engine and receive-engine set inputs. When a set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: `irq` is high exactly when the bitwise AND of the status word and the interrupt-enable word is nonzero. It follows each register update after one clock edge.
- R5: A write to the bus-mode word always stores bit 0 as zero.
- R6: A read of word index 0x008 returns 0x00001012, and writes to that index have no effect.
- R7: A write to the transmit poll-demand word raises `tx_kick` for exactly one cycle, starting at the clock edge that accepts the write. It stores nothing, and the word reads as zero.
- R8: A write to the receive or transmit base word also loads the same value into the matching current-descriptor register. The current-descriptor registers can also be written directly.
- R9: Writes to undecoded indices (for example 0x3C2, 0x3C8, 0x000) change nothing, and reads from them return zero.
- R10: After reset, every register, `tx_kick`, `bus_rvalid` and `irq` are zero.
- R11: `tx_enable` is control bit 13 and `rx_enable` is control bit 1.
- R12: A read request returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. The data reflects the register contents before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| tx_evt_set | input | 32 | Status set pulses from the transmit engine |
| rx_evt_set | input | 32 | Status set pulses from the receive engine |
| tx_kick | output | 1 | One-cycle transmit poll pulse |
| bus_mode | output | 32 | Bus-mode word |
| tx_base | output | 32 | Transmit list base |
| rx_base | output | 32 | Receive list base |
| cur_tx_desc | output | 32 | Current transmit descriptor pointer |
| cur_rx_desc | output | 32 | Current receive descriptor pointer |
| dma_ctrl | output | 32 | DMA control word |
| tx_enable | output | 1 | Transmit run bit |
| rx_enable | output | 1 | Receive run bit |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can meet on the same status bit in one cycle: an engine set pulse and a software write-one clear. The bench provokes this in two ways. Directed cycles drive a status write together with set pulses on overlapping and disjoint bits, and random traffic draws set pulses during status writes. Each result is judged against a model that applies the clear first and the set last, and the interrupt line is checked against that model after every cycle.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned CSR_DW     = 32;
  localparam int unsigned CSR_IDX_W  = 10;

  localparam logic [CSR_IDX_W-1:0] IDX_BUSMODE = 10'h3C0;
  localparam logic [CSR_IDX_W-1:0] IDX_TXPOLL  = 10'h3C1;
  localparam logic [CSR_IDX_W-1:0] IDX_RXBASE  = 10'h3C3;
  localparam logic [CSR_IDX_W-1:0] IDX_TXBASE  = 10'h3C4;
  localparam logic [CSR_IDX_W-1:0] IDX_STATUS  = 10'h3C5;
  localparam logic [CSR_IDX_W-1:0] IDX_CTRL    = 10'h3C6;
  localparam logic [CSR_IDX_W-1:0] IDX_INTEN   = 10'h3C7;
  localparam logic [CSR_IDX_W-1:0] IDX_CURTX   = 10'h3D2;
  localparam logic [CSR_IDX_W-1:0] IDX_CURRX   = 10'h3D3;
  localparam logic [CSR_IDX_W-1:0] IDX_VERSION = 10'h008;

  localparam logic [CSR_DW-1:0] VERSION_WORD = 32'h0000_1012;

  // status bit positions used by the engines
  localparam int unsigned STB_TX_DONE  = 0;
  localparam int unsigned STB_TX_STOP  = 1;
  localparam int unsigned STB_TX_NOBUF = 2;
  localparam int unsigned STB_RX_DONE  = 6;
  localparam int unsigned STB_RX_NOBUF = 7;
  localparam int unsigned STB_ABN_SUM  = 15;
  localparam int unsigned STB_NRM_SUM  = 16;

  localparam int unsigned CTL_TX_RUN = 13;
  localparam int unsigned CTL_RX_RUN = 1;

  // plain storage words
  typedef enum int unsigned {
    WD_BUSMODE = 0,
    WD_RXBASE  = 1,
    WD_TXBASE  = 2,
    WD_CTRL    = 3,
    WD_INTEN   = 4,
    WD_CURTX   = 5,
    WD_CURRX   = 6
  } word_id_e;

  localparam int unsigned NUM_WORDS = 7;

  typedef struct packed {
    logic busmode;
    logic txpoll;
    logic rxbase;
    logic txbase;
    logic status;
    logic ctrl;
    logic inten;
    logic curtx;
    logic currx;
    logic version;
  } csr_sel_t;

endpackage

// File: rtl/dma_csr_rst_sync.sv
module dma_csr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int unsigned IDX_W = CSR_IDX_W
) (
  input  logic [IDX_W-1:0] idx,
  output csr_sel_t         sel
);

  always_comb begin
    sel         = '0;
    sel.busmode = (idx == IDX_W'(IDX_BUSMODE));
    sel.txpoll  = (idx == IDX_W'(IDX_TXPOLL));
    sel.rxbase  = (idx == IDX_W'(IDX_RXBASE));
    sel.txbase  = (idx == IDX_W'(IDX_TXBASE));
    sel.status  = (idx == IDX_W'(IDX_STATUS));
    sel.ctrl    = (idx == IDX_W'(IDX_CTRL));
    sel.inten   = (idx == IDX_W'(IDX_INTEN));
    sel.curtx   = (idx == IDX_W'(IDX_CURTX));
    sel.currx   = (idx == IDX_W'(IDX_CURRX));
    sel.version = (idx == IDX_W'(IDX_VERSION));
  end

endmodule

// File: rtl/dma_csr_word.sv
module dma_csr_word #(
  parameter int unsigned     W         = 32,
  parameter logic [W-1:0]    ZERO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] d;

  always_comb begin
    d = wdata & ~ZERO_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_a,
  input  logic [W-1:0] set_b,
  input  logic [W-1:0] inten,
  output logic [W-1:0] status_q,
  output logic         irq
);

  logic [W-1:0] set_all;
  logic [W-1:0] clr_eff;
  logic [W-1:0] status_d;
  logic         status_en;

  always_comb begin
    set_all   = set_a | set_b;
    clr_eff   = clr_en ? clr_mask : '0;
    status_d  = (status_q & ~clr_eff) | set_all;
    status_en = clr_en | (|set_all);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign irq = |(status_q & inten);

  AST_SET_BITS_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ((status_q & $past(set_all)) == $past(set_all))); // R3

  AST_W1C_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_all == '0) |=>
      (status_q == ($past(status_q) & ~$past(clr_mask)))); // R2

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && set_all == '0) |=> $stable(status_q)); // R2

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0 && inten != '0)); // R4

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] tx_evt_set,
  input  logic [DATA_W-1:0] rx_evt_set,
  output logic              tx_kick,
  output logic [DATA_W-1:0] bus_mode,
  output logic [DATA_W-1:0] tx_base,
  output logic [DATA_W-1:0] rx_base,
  output logic [DATA_W-1:0] cur_tx_desc,
  output logic [DATA_W-1:0] cur_rx_desc,
  output logic [DATA_W-1:0] dma_ctrl,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              irq
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic              rst_n_s;
  logic [IDX_W-1:0]  word_idx;
  csr_sel_t          sel;
  logic              wr_fire;
  logic              rd_fire;
  logic [NUM_WORDS-1:0] word_we;
  logic [DATA_W-1:0] word_q [NUM_WORDS];
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] rd_next;
  logic              kick_d;

  dma_csr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign wr_fire  = bus_valid & bus_write;
  assign rd_fire  = bus_valid & ~bus_write;

  dma_csr_decode #(.IDX_W(IDX_W)) u_dec (
    .idx (word_idx),
    .sel (sel)
  );

  // write enables per storage word; base writes also load the current pointer
  always_comb begin
    word_we             = '0;
    word_we[WD_BUSMODE] = wr_fire & sel.busmode;
    word_we[WD_RXBASE]  = wr_fire & sel.rxbase;
    word_we[WD_TXBASE]  = wr_fire & sel.txbase;
    word_we[WD_CTRL]    = wr_fire & sel.ctrl;
    word_we[WD_INTEN]   = wr_fire & sel.inten;
    word_we[WD_CURTX]   = wr_fire & (sel.curtx | sel.txbase);
    word_we[WD_CURRX]   = wr_fire & (sel.currx | sel.rxbase);
  end

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    localparam logic [DATA_W-1:0] ZMASK =
      (gi == WD_BUSMODE) ? DATA_W'(1) : '0;
    dma_csr_word #(.W(DATA_W), .ZERO_MASK(ZMASK)) u_word (
      .clk   (clk),
      .rst_n (rst_n_s),
      .we    (word_we[gi]),
      .wdata (bus_wdata),
      .q     (word_q[gi])
    );
  end

  dma_csr_status #(.W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_en   (wr_fire & sel.status),
    .clr_mask (bus_wdata),
    .set_a    (tx_evt_set),
    .set_b    (rx_evt_set),
    .inten    (word_q[WD_INTEN]),
    .status_q (status_q),
    .irq      (irq)
  );

  // read-back selection
  always_comb begin
    rd_next = '0;
    unique case (1'b1)
      sel.busmode: rd_next = word_q[WD_BUSMODE];
      sel.rxbase:  rd_next = word_q[WD_RXBASE];
      sel.txbase:  rd_next = word_q[WD_TXBASE];
      sel.status:  rd_next = status_q;
      sel.ctrl:    rd_next = word_q[WD_CTRL];
      sel.inten:   rd_next = word_q[WD_INTEN];
      sel.curtx:   rd_next = word_q[WD_CURTX];
      sel.currx:   rd_next = word_q[WD_CURRX];
      sel.version: rd_next = DATA_W'(VERSION_WORD);
      default:     rd_next = '0;
    endcase
  end

  assign kick_d = wr_fire & sel.txpoll;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      bus_rvalid <= 1'b0;
      tx_kick    <= 1'b0;
    end else begin
      bus_rvalid <= rd_fire;
      tx_kick    <= kick_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      bus_rdata <= '0;
    end else if (rd_fire) begin
      bus_rdata <= rd_next;
    end
  end

  assign bus_mode    = word_q[WD_BUSMODE];
  assign rx_base     = word_q[WD_RXBASE];
  assign tx_base     = word_q[WD_TXBASE];
  assign dma_ctrl    = word_q[WD_CTRL];
  assign cur_tx_desc = word_q[WD_CURTX];
  assign cur_rx_desc = word_q[WD_CURRX];
  assign tx_enable   = word_q[WD_CTRL][CTL_TX_RUN];
  assign rx_enable   = word_q[WD_CTRL][CTL_RX_RUN];

  AST_BUSMODE_LSB_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_fire && sel.busmode) |=>
      (bus_mode == ($past(bus_wdata) & ~DATA_W'(1)))); // R5

  AST_KICK_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tx_kick) |-> $past(wr_fire && word_idx == IDX_W'(IDX_TXPOLL))); // R7

  AST_TXBASE_LOADS_PTR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_fire && sel.txbase) |=> (cur_tx_desc == tx_base)); // R8

  AST_RXBASE_LOADS_PTR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_fire && sel.rxbase) |=> (cur_rx_desc == rx_base)); // R8

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rvalid |-> $past(rd_fire)); // R12

  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_fire && word_idx == IDX_W'(IDX_VERSION)) |=>
      (bus_rdata == DATA_W'(VERSION_WORD))); // R6

endmodule

// File: tb/dma_csr_bank_test.sv
`timescale 1ns/1ps
module dma_csr_bank_test;
  import dma_csr_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] tx_evt_set;
  logic [31:0] rx_evt_set;
  logic        tx_kick;
  logic [31:0] bus_mode, tx_base, rx_base, cur_tx_desc, cur_rx_desc, dma_ctrl;
  logic        tx_enable, rx_enable, irq;

  int checks;
  int failures;

  // model state
  logic [31:0] m_bus, m_rxb, m_txb, m_st, m_ctl, m_ie, m_ctx, m_crx;

  dma_csr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tx_evt_set(tx_evt_set), .rx_evt_set(rx_evt_set),
    .tx_kick(tx_kick), .bus_mode(bus_mode), .tx_base(tx_base), .rx_base(rx_base),
    .cur_tx_desc(cur_tx_desc), .cur_rx_desc(cur_rx_desc), .dma_ctrl(dma_ctrl),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [9:0] idx);
    case (idx)
      10'h3C0: return m_bus;
      10'h3C3: return m_rxb;
      10'h3C4: return m_txb;
      10'h3C5: return m_st;
      10'h3C6: return m_ctl;
      10'h3C7: return m_ie;
      10'h3D2: return m_ctx;
      10'h3D3: return m_crx;
      10'h008: return 32'h0000_1012;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [9:0] idx, input logic [31:0] d);
    case (idx)
      10'h3C0: m_bus = d & 32'hFFFF_FFFE;
      10'h3C3: begin m_rxb = d; m_crx = d; end
      10'h3C4: begin m_txb = d; m_ctx = d; end
      10'h3C5: m_st = m_st & ~d;
      10'h3C6: m_ctl = d;
      10'h3C7: m_ie = d;
      10'h3D2: m_ctx = d;
      10'h3D3: m_crx = d;
      default: ;
    endcase
  endtask

  // one bus cycle; called at a negedge, returns at the next negedge
  task automatic cycle(input logic v, input logic w, input logic [9:0] idx,
                       input logic [31:0] d, input logic [31:0] ts,
                       input logic [31:0] rs, input string tag);
    logic [31:0] exp_rd;
    bus_valid  = v;
    bus_write  = w;
    bus_addr   = {idx, 2'b00};
    bus_wdata  = d;
    tx_evt_set = ts;
    rx_evt_set = rs;
    exp_rd = model_read(idx);
    @(negedge clk);
    if (v && !w) begin
      chk({tag, " R12 rvalid"}, {31'b0, bus_rvalid}, 32'd1);
      chk({tag, " R1 rdata"}, bus_rdata, exp_rd);
    end else begin
      chk({tag, " R12 no rvalid"}, {31'b0, bus_rvalid}, 32'd0);
    end
    chk({tag, " R7 kick"}, {31'b0, tx_kick}, {31'b0, (v && w && idx == 10'h3C1)});
    if (v && w) model_write(idx, d);
    m_st = m_st | ts | rs;
    chk({tag, " R4 irq"}, {31'b0, irq}, {31'b0, |(m_st & m_ie)});
    chk({tag, " R8 curtx"}, cur_tx_desc, m_ctx);
    chk({tag, " R8 currx"}, cur_rx_desc, m_crx);
    chk({tag, " R11 txen"}, {31'b0, tx_enable}, {31'b0, m_ctl[13]});
    chk({tag, " R11 rxen"}, {31'b0, rx_enable}, {31'b0, m_ctl[1]});
    chk({tag, " R5 busmode"}, bus_mode, m_bus);
    bus_valid  = 1'b0;
    tx_evt_set = '0;
    rx_evt_set = '0;
  endtask

  task automatic rd(input logic [9:0] idx, input string tag);
    cycle(1'b1, 1'b0, idx, 32'h0, 32'h0, 32'h0, tag);
  endtask

  task automatic wr(input logic [9:0] idx, input logic [31:0] d, input string tag);
    cycle(1'b1, 1'b1, idx, d, 32'h0, 32'h0, tag);
  endtask

  initial begin : watchdog
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [9:0] ADDR_POOL [14] = '{
    10'h3C0, 10'h3C1, 10'h3C3, 10'h3C4, 10'h3C5, 10'h3C6, 10'h3C7,
    10'h3D2, 10'h3D3, 10'h008, 10'h3C2, 10'h3C8, 10'h000, 10'h3FF };

  initial begin : main
    checks = 0; failures = 0;
    m_bus = '0; m_rxb = '0; m_txb = '0; m_st = '0;
    m_ctl = '0; m_ie = '0; m_ctx = '0; m_crx = '0;
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    tx_evt_set = '0; rx_evt_set = '0;
    rst_n = 0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 irq", {31'b0, irq}, 32'd0);
    chk("R10 kick", {31'b0, tx_kick}, 32'd0);
    chk("R10 rvalid", {31'b0, bus_rvalid}, 32'd0);
    rd(10'h3C5, "R10 status");
    rd(10'h3C6, "R10 ctrl");
    rd(10'h3C0, "R10 busmode");

    // R6 version, write ignored
    rd(10'h008, "R6 version");
    wr(10'h008, 32'hDEAD_BEEF, "R6 wr");
    rd(10'h008, "R6 version after wr");

    // R5 bus mode bit 0
    wr(10'h3C0, 32'hFFFF_FFFF, "R5 wr");
    rd(10'h3C0, "R5 rd");

    // R7 poll: pulse then gone, reads zero
    wr(10'h3C1, 32'h1, "R7 poll");
    cycle(1'b0, 1'b0, 10'h0, 32'h0, 32'h0, 32'h0, "R7 after");
    rd(10'h3C1, "R7 rd");

    // R8 base loads pointer, then direct pointer write
    wr(10'h3C4, 32'h1000_0040, "R8 txbase");
    wr(10'h3C3, 32'h2000_0080, "R8 rxbase");
    wr(10'h3D2, 32'h1000_0060, "R8 curtx direct");
    rd(10'h3C4, "R8 txbase rd");
    rd(10'h3D2, "R8 curtx rd");

    // R9 undecoded
    wr(10'h3C2, 32'hFFFF_FFFF, "R9 wr 3C2");
    wr(10'h3C8, 32'hFFFF_FFFF, "R9 wr 3C8");
    rd(10'h3C2, "R9 rd 3C2");
    rd(10'h000, "R9 rd 000");

    // R11 control bits
    wr(10'h3C6, 32'h0000_2002, "R11 ctrl");

    // R2/R4 set, enable, clear
    cycle(1'b0, 1'b0, 10'h0, 32'h0, 32'h0000_0001, 32'h0001_0040, "R3 sets");
    wr(10'h3C7, 32'h0000_0040, "R4 enable rx");
    wr(10'h3C5, 32'h0000_0040, "R2 clear rx");
    rd(10'h3C5, "R2 remaining");

    // R3 collision: set and clear same bit
    cycle(1'b1, 1'b1, 10'h3C5, 32'hFFFF_FFFF, 32'h0000_0004, 32'h0000_0080, "R3 collide");
    rd(10'h3C5, "R3 collide rd");
    wr(10'h3C7, 32'hFFFF_FFFF, "R4 enable all");
    cycle(1'b1, 1'b1, 10'h3C5, 32'h0000_0004, 32'h0000_0000, 32'h0000_8000, "R3 disjoint");
    rd(10'h3C5, "R3 disjoint rd");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [9:0]  a;
      logic [31:0] d, ts, rs;
      logic        v, w;
      a  = ADDR_POOL[$urandom_range(0, 13)];
      d  = $urandom();
      v  = ($urandom_range(0, 7) != 0);
      w  = $urandom_range(0, 1) == 1;
      ts = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom()) : 32'h0;
      rs = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom()) : 32'h0;
      cycle(v, w, a, d, ts, rs, "RND R1 R2 R3");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule